// File: doc/BRIEF.md
# Per-Key Atomic Sampling Counter

This block is one stateful stage of a packet pipeline. It holds a table of counters, one per key value. Each clock cycle it can take one packet descriptor made of a key and a predicate bit. An earlier stateless stage has already worked out the predicate from the packet's fields. In a single cycle the block reads the counter that the key selects, decides what the new value is, and writes it back. The read and the write happen in the same stage, so each packet's update is atomic. Back-to-back packets on the same key therefore always see the value left by the packet before them.

The block has two modes. In sampling mode a counter counts predicated packets up to a programmable period. The packet that completes the period is flagged for sampling and the counter restarts at zero. In plain count mode the counter just increments and nothing is flagged. Every packet gets a registered result one cycle after it is accepted. The result carries the key, the sample flag and the counter value after the update.

The table has no reset of its own. Instead, reset and a clear request both start a sweep that zeroes one entry per cycle.

Top module: `stateful_sampler`

## Requirements
- R1: While reset is held, out_valid is low and clr_busy is high. Once reset is released, clr_busy stays high for exactly 256 sampled cycles and then falls. After that every counter reads zero, the mode is sampling and the period is 100.
- R2: A packet accepted on one clock edge shows up with out_valid high and out_key equal to its key after the next edge. A new packet can be accepted every cycle.
- R3: A packet with in_pred low leaves its counter unchanged. Its result has out_sample low and out_count equal to the stored value.
- R4: In sampling mode (cfg_mode = 0), a predicated packet whose stored value is below period-1 raises the counter by one and reports no sample. Otherwise the counter becomes 0 and out_sample is high. With the default period, the 100th predicated packet on a fresh key is sampled.
- R5: In count mode (cfg_mode = 1), a predicated packet raises the counter by one, modulo 2^32, and out_sample stays low.
- R6: Predicated packets on the same key in consecutive cycles each add exactly one. None is lost.
- R7: A packet changes only the counter of its own key.
- R8: A pulse on cfg_we loads cfg_mode and cfg_period at that clock edge. A packet accepted on the same edge still uses the old settings.
- R9: After the period is changed, a counter whose stored value is already at or above the new period-1 wraps to 0 on its next predicated packet, and that packet is sampled.
- R10: A clr_start pulse while idle raises clr_busy for exactly 256 cycles and zeroes every counter. clr_start is ignored while a sweep is running.
- R11: A packet accepted while clr_busy is high still produces a result. Its out_sample is low and its out_count is 0, and it updates no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet descriptor present |
| in_key | input | 8 | Counter index for the packet |
| in_pred | input | 1 | Upstream predicate; 1 requests an increment |
| cfg_we | input | 1 | Load mode and period this cycle |
| cfg_mode | input | 1 | 0 = sampling, 1 = plain count |
| cfg_period | input | 32 | Sampling period |
| clr_start | input | 1 | Start a sweep that zeroes all counters |
| out_valid | output | 1 | Result present, one cycle after the packet |
| out_key | output | 8 | Key of the result |
| out_sample | output | 1 | Packet selected for sampling |
| out_count | output | 32 | Counter value after the update |
| clr_busy | output | 1 | Zeroing sweep in progress |

## Verification
The hardest cases to reach are the ones where a packet collides with other activity: a configuration write on the same edge, a lowered period that catches a counter already past the new limit, and a packet that arrives in the middle of a clear sweep. The stimulus sets each of these up on purpose. It pushes a counter up in count mode and then switches to a short period. It drives a configuration write and a packet in the same cycle. It injects a packet and a second clear pulse partway through a sweep. Each case is then checked again after the fact, by reading the affected key through a later packet.

// File: rtl/stateful_sampler.sv
module stateful_sampler #(
  parameter int KEY_W      = 8,
  parameter int CNT_W      = 32,
  parameter int DEF_PERIOD = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic             in_pred,
  input  logic             cfg_we,
  input  logic             cfg_mode,
  input  logic [CNT_W-1:0] cfg_period,
  input  logic             clr_start,
  output logic             out_valid,
  output logic [KEY_W-1:0] out_key,
  output logic             out_sample,
  output logic [CNT_W-1:0] out_count,
  output logic             clr_busy
);
  localparam int DEPTH = 1 << KEY_W;

  logic [CNT_W-1:0] table_q [DEPTH];
  logic [CNT_W-1:0] period_q;
  logic             mode_q;
  logic [KEY_W-1:0] sweep_q;

  wire [CNT_W-1:0] cur   = table_q[in_key];
  wire [CNT_W-1:0] limit = period_q - CNT_W'(1);
  wire             wrap  = !mode_q && (cur >= limit);
  wire             bump  = in_valid && in_pred && !clr_busy;
  wire [CNT_W-1:0] nxt   = wrap ? '0 : cur + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_key    <= '0;
      out_sample <= 1'b0;
      out_count  <= '0;
    end else begin
      out_valid  <= in_valid;
      out_key    <= in_key;
      out_sample <= bump && wrap;
      out_count  <= clr_busy ? '0 : (bump ? nxt : cur);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= CNT_W'(DEF_PERIOD);
      mode_q   <= 1'b0;
    end else if (cfg_we) begin
      period_q <= cfg_period;
      mode_q   <= cfg_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_busy <= 1'b1;
      sweep_q  <= '0;
    end else if (clr_busy) begin
      sweep_q <= sweep_q + KEY_W'(1);
      if (sweep_q == KEY_W'(DEPTH - 1)) clr_busy <= 1'b0;
    end else if (clr_start) begin
      clr_busy <= 1'b1;
      sweep_q  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (clr_busy) table_q[sweep_q] <= '0;
    else if (bump) table_q[in_key] <= nxt;
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_key == $past(in_key)));
  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_sample_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sample |-> (out_valid && out_count == '0));
  assert_no_pred_no_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_pred) |=> !out_sample);
  assert_count_mode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> !out_sample);
  assert_sweep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && in_valid) |=> (!out_sample && out_count == '0));
endmodule

// File: tb/stateful_sampler_test.sv
module stateful_sampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_key = '0;
  logic        in_pred = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_mode = 1'b0;
  logic [31:0] cfg_period = '0;
  logic        clr_start = 1'b0;
  logic        out_valid, out_sample, clr_busy;
  logic [7:0]  out_key;
  logic [31:0] out_count;

  int checks = 0;
  int fails = 0;

  // key, pred, expected sample, expected count (period 3, sampling mode)
  localparam logic [41:0] VEC [NVEC] = '{
    {8'd5,   1'b1, 1'b0, 32'd1}, {8'd5,   1'b1, 1'b0, 32'd2},
    {8'd5,   1'b1, 1'b1, 32'd0}, {8'd5,   1'b0, 1'b0, 32'd0},
    {8'd9,   1'b1, 1'b0, 32'd1}, {8'd5,   1'b1, 1'b0, 32'd1},
    {8'd9,   1'b0, 1'b0, 32'd1}, {8'd9,   1'b1, 1'b0, 32'd2},
    {8'd9,   1'b1, 1'b1, 32'd0}, {8'd5,   1'b1, 1'b0, 32'd2},
    {8'd5,   1'b1, 1'b1, 32'd0}, {8'd0,   1'b1, 1'b0, 32'd1},
    {8'd255, 1'b1, 1'b0, 32'd1}, {8'd255, 1'b1, 1'b0, 32'd2}
  };

  stateful_sampler uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key), .in_pred(in_pred),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_period(cfg_period), .clr_start(clr_start),
    .out_valid(out_valid), .out_key(out_key), .out_sample(out_sample),
    .out_count(out_count), .clr_busy(clr_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pkt(input logic [7:0] k, input logic p, input logic es,
                     input logic [31:0] ec, input string req);
    in_valid = 1'b1; in_key = k; in_pred = p;
    @(negedge clk);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " key"}, 32'(out_key), 32'(k));
    check({req, " sample"}, 32'(out_sample), 32'(es));
    check({req, " count"}, out_count, ec);
  endtask

  task automatic idle();
    in_valid = 1'b0; in_pred = 1'b0;
  endtask

  task automatic setcfg(input logic m, input logic [31:0] p);
    idle();
    cfg_we = 1'b1; cfg_mode = m; cfg_period = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", 32'(out_valid), 32'd0);
    check("R1 reset busy", 32'(clr_busy), 32'd1);
    rst_n = 1'b1;
    n = 0;
    while (clr_busy && n < 1000) begin n++; @(negedge clk); end
    check("R1 sweep length", n, 256);
    check("R2 idle out_valid", 32'(out_valid), 32'd0);

    for (int i = 1; i < 100; i++) pkt(8'd7, 1'b1, 1'b0, 32'(i), "R4 default period");
    pkt(8'd7, 1'b1, 1'b1, 32'd0, "R4 100th sampled");
    idle(); @(negedge clk);
    check("R2 gap", 32'(out_valid), 32'd0);

    setcfg(1'b0, 32'd3);
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][33]) pkt(VEC[i][41:34], 1'b1, VEC[i][32], VEC[i][31:0], "R4 R6 R7 table");
      else pkt(VEC[i][41:34], 1'b0, VEC[i][32], VEC[i][31:0], "R3 table");
    end
    pkt(8'd7, 1'b0, 1'b0, 32'd0, "R7 untouched key");

    setcfg(1'b1, 32'd3);
    for (int i = 1; i <= 5; i++) pkt(8'd20, 1'b1, 1'b0, 32'(i), "R5 count mode");
    setcfg(1'b0, 32'd3);
    pkt(8'd20, 1'b1, 1'b1, 32'd0, "R9 lowered limit");

    setcfg(1'b1, 32'd3);
    cfg_we = 1'b1; cfg_mode = 1'b0; cfg_period = 32'd1;
    pkt(8'd40, 1'b1, 1'b0, 32'd1, "R8 old config");
    cfg_we = 1'b0;
    pkt(8'd40, 1'b1, 1'b1, 32'd0, "R8 new config");
    pkt(8'd40, 1'b1, 1'b1, 32'd0, "R8 period one");

    setcfg(1'b0, 32'd3);
    clr_start = 1'b1;
    @(negedge clk);
    clr_start = 1'b0;
    n = 0;
    while (clr_busy && n < 1000) begin
      clr_start = (n == 100);
      if (n == 5) begin in_valid = 1'b1; in_key = 8'd255; in_pred = 1'b1; end
      else idle();
      if (n == 6) begin
        check("R11 busy valid", 32'(out_valid), 32'd1);
        check("R11 busy sample", 32'(out_sample), 32'd0);
        check("R11 busy count", out_count, 32'd0);
      end
      n++;
      @(negedge clk);
    end
    clr_start = 1'b0;
    check("R10 sweep length with retrigger", n, 256);
    pkt(8'd255, 1'b1, 1'b0, 32'd1, "R11 no update R10 cleared");
    pkt(8'd20, 1'b0, 1'b0, 32'd0, "R10 cleared");
    pkt(8'd7, 1'b0, 1'b0, 32'd0, "R10 cleared");
    idle(); @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule